// File: doc/BRIEF.md
# Host-Side Parallel Byte Port

This block lets an external host exchange single bytes with an on-chip processor over an 8-bit parallel bus. The host uses three active-low strobes, for chip select, read and write. It reads a byte that the processor left in an output latch, and it writes a byte that the processor later collects from an input latch. The host strobes are asynchronous to the block. They pass through a synchronizer chain, and the block treats the end of an access as the moment the combined active condition drops.

The processor has four controls. It can load the output latch, collect the input latch, and read or write a control byte. The control byte reports buffer-full flags in each direction, an overflow flag and the port enable. When a host access finishes, the block raises a sticky interrupt flag. The bus is modelled as separate in, out and output-enable signals, so the pad ring can build the tristate driver.

Top module: `slave_port`

## Requirements
- R1: After reset the control byte reads 0x00, the interrupt flag is low, the output-enable is low and the input latch reads 0x00.
- R2: The control byte holds input-full at bit 7, output-full at bit 6, input-overflow at bit 5 and port enable at bit 4. Bits 3..0 read zero. A control write takes bit 4 as the new enable, and writing ones to bits 7, 6 and 5 sets none of those flags.
- R3: With the port enabled, a processor load of the output latch sets output-full and leaves the output-enable low.
- R4: While read and chip select are both low and the port is enabled, the output-enable is high, the bus output carries the output latch, and output-full clears.
- R5: During a host read the interrupt flag stays low. It rises only after the read access ends.
- R6: During a host write, input-full stays low. When chip select or write returns high, the bus byte is captured, input-full sets and the interrupt flag rises.
- R7: The input latch output shows the captured byte, and a processor collect pulse clears input-full.
- R8: A host write that completes while input-full is set sets input-overflow. Input-full stays set and the previously captured byte is kept.
- R9: A control write with bit 5 at zero clears input-overflow and leaves input-full unchanged. A control write with bit 5 at one leaves input-overflow as it is.
- R10: Clearing the port enable clears all three flags. While the port is disabled, host strobes capture nothing, the bus is never driven, and a latch load does not set output-full.
- R11: Only the interrupt-clear input clears the interrupt flag. A transfer completion in the same cycle wins over the clear.
- R12: Read or write strobes with chip select high cause no transfer, no bus drive and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostCsN | input | 1 | Host chip select, active low |
| busIn | input | 8 | Byte present on the host bus |
| busOut | output | 8 | Byte the block offers to the bus |
| busOe | output | 1 | High while the block drives the bus |
| cpuOutWe | input | 1 | Load the output latch from cpuWdata |
| cpuWdata | input | 8 | Byte for the output latch |
| cpuInRe | input | 1 | Collect pulse for the input latch |
| cpuRdata | output | 8 | Input latch contents |
| cpuCtlWe | input | 1 | Control byte write strobe |
| cpuCtlWdata | input | 8 | Control byte write value |
| ctlRdata | output | 8 | Control byte read value |
| irqClr | input | 1 | Clears the interrupt flag |
| irqFlag | output | 1 | Sticky transfer-complete flag |

## Verification
The bench sweeps every byte value through a full round trip. Each pass makes a processor load, a host read, a host write and a processor collect, and the write alternates between ending on chip select and ending on write. A design that fired the interrupt at the start of a strobe, or set input-full before the access closed, would fail the mid-access checks. A design that overwrote the held byte on overflow, cleared input-full when clearing overflow, or let a same-cycle clear defeat a completion would show the wrong control byte or interrupt level. The bench also toggles strobes with chip select high and with the port disabled, which catches any transfer that is not gated by chip select or by the enable.

// File: rtl/slave_port_pkg.sv
package slave_port_pkg;
  localparam int unsigned IBF_BIT  = 7;
  localparam int unsigned OBF_BIT  = 6;
  localparam int unsigned IBOV_BIT = 5;
  localparam int unsigned MODE_BIT = 4;
  localparam int unsigned STROBE_COUNT = 3;

  typedef struct packed {
    logic sampleBus;
    logic commitIn;
    logic loadOut;
  } dpStrobes_t;
endpackage

// File: rtl/slave_port_sync.sv
module slave_port_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/slave_port_ctrl.sv
module slave_port_ctrl
  import slave_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostCsN,
  input  logic              cpuOutWe,
  input  logic              cpuInRe,
  input  logic              cpuCtlWe,
  input  logic [DATA_W-1:0] cpuCtlWdata,
  input  logic              irqClr,
  output dpStrobes_t        strobes,
  output logic              busOe,
  output logic [DATA_W-1:0] ctlRdata,
  output logic              irqFlag
);
  logic [STROBE_COUNT-1:0] rawActive;
  logic [STROBE_COUNT-1:0] syncActive;
  logic rdActive, wrActive, prevRd, prevWr, rdEnd, wrEnd;
  logic modeEn, modeNext, ibf, obf, ibov;
  logic overflowHit, commitIn;
  logic unusedCtlBits;

  // index 0 read, 1 write, 2 chip select; all turned active high
  assign rawActive = {~hostCsN, ~hostWrN, ~hostRdN};

  for (genvar g = 0; g < STROBE_COUNT; g++) begin : g_sync
    slave_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rstN   (rstN),
      .asyncIn(rawActive[g]),
      .syncOut(syncActive[g])
    );
  end

  assign rdActive = syncActive[0] & syncActive[2];
  assign wrActive = syncActive[1] & syncActive[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd <= 1'b0;
      prevWr <= 1'b0;
    end else begin
      prevRd <= rdActive;
      prevWr <= wrActive;
    end
  end

  assign rdEnd = prevRd & ~rdActive;
  assign wrEnd = prevWr & ~wrActive;

  assign modeNext    = cpuCtlWe ? cpuCtlWdata[MODE_BIT] : modeEn;
  assign overflowHit = wrEnd & modeEn & ibf & ~cpuInRe;
  assign commitIn    = wrEnd & modeEn & ~overflowHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn  <= 1'b0;
      ibf     <= 1'b0;
      obf     <= 1'b0;
      ibov    <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      modeEn <= modeNext;

      if (!modeNext)     ibf <= 1'b0;
      else if (commitIn) ibf <= 1'b1;
      else if (cpuInRe)  ibf <= 1'b0;

      if (!modeNext)                obf <= 1'b0;
      else if (cpuOutWe && modeEn)  obf <= 1'b1;
      else if (rdActive && modeEn)  obf <= 1'b0;

      if (!modeNext)                                  ibov <= 1'b0;
      else if (overflowHit)                           ibov <= 1'b1;
      else if (cpuCtlWe && !cpuCtlWdata[IBOV_BIT])    ibov <= 1'b0;

      if ((rdEnd || wrEnd) && modeEn) irqFlag <= 1'b1;
      else if (irqClr)                irqFlag <= 1'b0;
    end
  end

  // bus drive follows the raw pins so data is valid early in the strobe
  assign busOe = modeEn & ~hostRdN & ~hostCsN;

  always_comb begin
    ctlRdata           = '0;
    ctlRdata[IBF_BIT]  = ibf;
    ctlRdata[OBF_BIT]  = obf;
    ctlRdata[IBOV_BIT] = ibov;
    ctlRdata[MODE_BIT] = modeEn;
  end

  assign strobes.sampleBus = wrActive & modeEn;
  assign strobes.commitIn  = commitIn;
  assign strobes.loadOut   = cpuOutWe;

  assign unusedCtlBits = ^{cpuCtlWdata[IBF_BIT], cpuCtlWdata[OBF_BIT],
                           cpuCtlWdata[MODE_BIT-1:0]};
endmodule

// File: rtl/slave_port_dp.sv
module slave_port_dp
  import slave_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [DATA_W-1:0] busIn,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] busOut,
  output logic [DATA_W-1:0] cpuRdata
);
  logic [DATA_W-1:0] holdReg, inLatch, outLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      inLatch  <= '0;
      outLatch <= '0;
    end else begin
      if (strobes.sampleBus) holdReg  <= busIn;
      if (strobes.commitIn)  inLatch  <= holdReg;
      if (strobes.loadOut)   outLatch <= cpuWdata;
    end
  end

  assign busOut   = outLatch;
  assign cpuRdata = inLatch;
endmodule

// File: rtl/slave_port.sv
module slave_port
  import slave_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic              hostCsN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic              cpuOutWe,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuInRe,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              cpuCtlWe,
  input  logic [DATA_W-1:0] cpuCtlWdata,
  output logic [DATA_W-1:0] ctlRdata,
  input  logic              irqClr,
  output logic              irqFlag
);
  dpStrobes_t strobes;

  slave_port_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostRdN    (hostRdN),
    .hostWrN    (hostWrN),
    .hostCsN    (hostCsN),
    .cpuOutWe   (cpuOutWe),
    .cpuInRe    (cpuInRe),
    .cpuCtlWe   (cpuCtlWe),
    .cpuCtlWdata(cpuCtlWdata),
    .irqClr     (irqClr),
    .strobes    (strobes),
    .busOe      (busOe),
    .ctlRdata   (ctlRdata),
    .irqFlag    (irqFlag)
  );

  slave_port_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .busIn   (busIn),
    .cpuWdata(cpuWdata),
    .busOut  (busOut),
    .cpuRdata(cpuRdata)
  );
endmodule

// File: rtl/slave_port_checker.sv
module slave_port_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cpuOutWe,
  input logic       cpuInRe,
  input logic       cpuCtlWe,
  input logic       ctlWrMode,
  input logic [3:0] flags,
  input logic       busOe,
  input logic       irqClr,
  input logic       irqFlag
);
  // flags: [3] input-full, [2] output-full, [1] overflow, [0] enable

  a_r3_obf_from_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> $past(cpuOutWe));

  a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> $past(flags[3]));

  a_r7_ibf_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flags[3]) |-> ($past(cpuInRe) || $past(cpuCtlWe && !ctlWrMode)));

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !flags[0] |-> (flags[3:1] == 3'b000 && !busOe));

  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag);
endmodule

bind slave_port slave_port_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuOutWe (cpuOutWe),
  .cpuInRe  (cpuInRe),
  .cpuCtlWe (cpuCtlWe),
  .ctlWrMode(cpuCtlWdata[4]),
  .flags    (ctlRdata[7:4]),
  .busOe    (busOe),
  .irqClr   (irqClr),
  .irqFlag  (irqFlag)
);

// File: tb/test_slave_port.sv
module test_slave_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRdN = 1'b1, hostWrN = 1'b1, hostCsN = 1'b1;
  logic [7:0] busIn = '0, cpuWdata = '0, cpuCtlWdata = '0;
  logic cpuOutWe = 1'b0, cpuInRe = 1'b0, cpuCtlWe = 1'b0, irqClr = 1'b0;
  logic [7:0] busOut, cpuRdata, ctlRdata;
  logic busOe, irqFlag;
  int runs = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  slave_port i_slave_port (
    .clk(clk), .rstN(rstN), .hostRdN(hostRdN), .hostWrN(hostWrN), .hostCsN(hostCsN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .cpuOutWe(cpuOutWe),
    .cpuWdata(cpuWdata), .cpuInRe(cpuInRe), .cpuRdata(cpuRdata), .cpuCtlWe(cpuCtlWe),
    .cpuCtlWdata(cpuCtlWdata), .ctlRdata(ctlRdata), .irqClr(irqClr), .irqFlag(irqFlag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ctlWrite(input logic [7:0] v);
    cpuCtlWdata = v; cpuCtlWe = 1'b1; tick(1); cpuCtlWe = 1'b0; tick(1);
  endtask

  task automatic loadOut(input logic [7:0] v);
    cpuWdata = v; cpuOutWe = 1'b1; tick(1); cpuOutWe = 1'b0; tick(1);
  endtask

  task automatic collect();
    cpuInRe = 1'b1; tick(1); cpuInRe = 1'b0; tick(1);
  endtask

  task automatic pulseIrqClr();
    irqClr = 1'b1; tick(1); irqClr = 1'b0; tick(1);
  endtask

  // host write; ends on write strobe if endByWr else on chip select
  task automatic hostWrite(input logic [7:0] v, input bit endByWr, input logic [7:0] ctlDuring);
    busIn = v; hostCsN = 1'b0; hostWrN = 1'b0; tick(5);
    check(ctlRdata == ctlDuring, "R6 flags during write", ctlRdata, ctlDuring);
    if (endByWr) hostWrN = 1'b1; else hostCsN = 1'b1;
    tick(5);
    hostWrN = 1'b1; hostCsN = 1'b1; tick(2);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    check(ctlRdata == 8'h00, "R1 ctl reset", ctlRdata, 8'h00);
    check(irqFlag == 1'b0, "R1 irq reset", irqFlag, 0);
    check(busOe == 1'b0, "R1 oe reset", busOe, 0);
    check(cpuRdata == 8'h00, "R1 latch reset", cpuRdata, 8'h00);

    // R10: disabled port ignores everything
    loadOut(8'hA5);
    check(ctlRdata == 8'h00, "R10 load while disabled", ctlRdata, 8'h00);
    hostWrite(8'h3C, 1'b0, 8'h00);
    check(ctlRdata == 8'h00 && cpuRdata == 8'h00, "R10 write while disabled", cpuRdata, 8'h00);
    hostRdN = 1'b0; hostCsN = 1'b0; tick(4);
    check(busOe == 1'b0, "R10 no drive while disabled", busOe, 0);
    hostRdN = 1'b1; hostCsN = 1'b1; tick(4);
    check(irqFlag == 1'b0, "R10 no irq while disabled", irqFlag, 0);

    // R2: enable and layout
    ctlWrite(8'hFF);
    check(ctlRdata == 8'h10, "R2 flags not settable, low bits zero", ctlRdata, 8'h10);
    ctlWrite(8'h10);
    check(ctlRdata == 8'h10, "R2 enable bit", ctlRdata, 8'h10);

    // R12: strobes without chip select
    busIn = 8'h77; hostWrN = 1'b0; hostRdN = 1'b0; tick(5);
    check(busOe == 1'b0, "R12 no drive without select", busOe, 0);
    hostWrN = 1'b1; hostRdN = 1'b1; tick(5);
    check(ctlRdata == 8'h10 && irqFlag == 1'b0, "R12 no transfer without select", ctlRdata, 8'h10);

    // full sweep of byte values
    for (int v = 0; v < 256; v++) begin
      logic [7:0] ob, ib;
      ob = 8'(v);
      ib = 8'((v * 37 + 11) & 255);
      loadOut(ob);
      check(ctlRdata == 8'h50, "R3 output-full after load", ctlRdata, 8'h50);
      check(busOe == 1'b0, "R3 no drive after load", busOe, 0);
      hostRdN = 1'b0; hostCsN = 1'b0; tick(5);
      check(busOe == 1'b1 && busOut == ob, "R4 bus drive", busOut, ob);
      check(ctlRdata == 8'h10, "R4 output-full cleared", ctlRdata, 8'h10);
      check(irqFlag == 1'b0, "R5 irq low during read", irqFlag, 0);
      hostRdN = 1'b1; hostCsN = 1'b1; tick(5);
      check(irqFlag == 1'b1, "R5 irq after read", irqFlag, 1);
      pulseIrqClr();
      check(irqFlag == 1'b0, "R11 irq cleared", irqFlag, 0);
      hostWrite(ib, v[0], 8'h10);
      check(ctlRdata == 8'h90, "R6 input-full set", ctlRdata, 8'h90);
      check(irqFlag == 1'b1, "R6 irq after write", irqFlag, 1);
      check(cpuRdata == ib, "R7 captured byte", cpuRdata, ib);
      collect();
      check(ctlRdata == 8'h10, "R7 collect clears input-full", ctlRdata, 8'h10);
      pulseIrqClr();
    end

    // R8 / R9: overflow
    hostWrite(8'h12, 1'b0, 8'h10);
    hostWrite(8'h34, 1'b1, 8'h90);
    check(ctlRdata == 8'hB0, "R8 overflow and full", ctlRdata, 8'hB0);
    check(cpuRdata == 8'h12, "R8 old byte kept", cpuRdata, 8'h12);
    ctlWrite(8'h30);
    check(ctlRdata == 8'hB0, "R9 writing one keeps overflow", ctlRdata, 8'hB0);
    ctlWrite(8'h10);
    check(ctlRdata == 8'h90, "R9 overflow cleared, full kept", ctlRdata, 8'h90);
    pulseIrqClr();

    // R11: completion beats same-cycle clear
    hostRdN = 1'b0; hostCsN = 1'b0; tick(5);
    hostRdN = 1'b1; hostCsN = 1'b1;
    tick(2);
    irqClr = 1'b1; tick(1); irqClr = 1'b0;
    check(irqFlag == 1'b1, "R11 set wins over clear", irqFlag, 1);
    tick(3);
    check(irqFlag == 1'b1, "R11 irq stays set", irqFlag, 1);
    pulseIrqClr();

    // R10: disable clears flags
    loadOut(8'h99);
    check(ctlRdata == 8'hD0, "R10 both full before disable", ctlRdata, 8'hD0);
    ctlWrite(8'h00);
    check(ctlRdata == 8'h00, "R10 disable clears flags", ctlRdata, 8'h00);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      runs++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule